// File: doc/BRIEF.md
# Debug Halt Control Register Block

This block holds the debugger's view of core run control. A debugger reaches it over a simple 32-bit register bus that has a select, a write strobe and a word address. Through it the debugger enables debug and then requests a halt, a single step, or interrupt masking while stepping. The core's state is reported back as live bits: lockup, sleep, halted, and ready for a register transfer. Two sticky flags are also reported, one for core reset and one for instruction retirement, and each clears when the status word is read. Guarding writes to the control word with a 16-bit key protects the run controls from stray bus traffic.

A separate cause register collects the reason for the last halt. Each cause bit is set by an event pulse from the core and is cleared when the debugger writes one to that bit. A selector word starts a transfer of one core register, either read or write. The transfer data word carries the value to the core on a write and receives the core's value on a read. A monitor word holds three enables: the watchpoint unit enable, catch on hard fault, and catch on reset.

Word addresses: 0 control/status, 1 halt cause, 2 transfer selector, 3 transfer data, 4 monitor enables. Bus reads are combinational in the access cycle. Writes and read side effects take place at the clock edge that ends the access.

Top module: `dbg_halt_ctl`

## Requirements
- R1: After reset the control bits, cause bits, sticky flags, selector and monitor bits are 0, transfer-ready is 1, and every request output is 0.
- R2: A write to address 0 updates control bits 3:0 (0 enable, 1 halt, 2 step, 3 mask) only when bus bits 31:16 equal 0xA05F. Any other key leaves all four bits unchanged.
- R3: halt_req, step_req and mask_int equal control bits 1, 2 and 3 respectively, each ANDed with enable bit 0.
- R4: A read of address 0 returns bit 19 lockup, bit 18 sleep, bit 17 halted, bit 16 transfer-ready and bits 3:0 the control bits.
- R5: Read bit 25 is set while core_reset is high. It stays set until a read of address 0 during which core_reset is low. That read still returns 1.
- R6: Read bit 24 is set by a core_retire pulse and cleared by a read of address 0. The read returns the value it had before being cleared.
- R7: Cause bits (4 external, 3 vector catch, 2 watchpoint, 1 breakpoint, 0 halt/step) are set by cause_ev and cleared by writing 1 to them at address 1. Writing 0 leaves a bit unchanged. An event in the same cycle as a clearing write wins.
- R8: A write to address 2 latches direction from bit 16 (1 = write core register) and index from bits 4:0. It raises xfer_req for exactly the next cycle and clears transfer-ready. The selector reads back in the same bit positions.
- R9: A core_xfer_done pulse sets transfer-ready. If the latched direction is read, it also loads core_xfer_rdata into the data word. If the direction is write, the data word is unchanged.
- R10: Address 3 is a 32-bit read/write data word, driven on xfer_wdata.
- R11: Address 4 holds watch enable (bit 24), hard-fault catch (bit 10) and reset catch (bit 0), driven on watch_en, vc_hardfault and vc_reset.
- R12: Bits without a function, and addresses 5 to 7, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| core_halted | input | 1 | Core is halted |
| core_sleep | input | 1 | Core is sleeping |
| core_lockup | input | 1 | Core is locked up |
| core_reset | input | 1 | Core is in or has been in reset |
| core_retire | input | 1 | Pulse: an instruction completed |
| core_xfer_done | input | 1 | Pulse: register transfer acknowledged |
| core_xfer_rdata | input | 32 | Register value returned by the core |
| cause_ev | input | 5 | Halt-cause event pulses |
| halt_req | output | 1 | Halt request to the core |
| step_req | output | 1 | Single-step request |
| mask_int | output | 1 | Mask interrupts while stepping |
| xfer_req | output | 1 | One-cycle register transfer request |
| xfer_write | output | 1 | Transfer direction, 1 = write |
| xfer_index | output | 5 | Core register index |
| xfer_wdata | output | 32 | Transfer data word |
| watch_en | output | 1 | Watchpoint unit enable |
| vc_hardfault | output | 1 | Catch on hard fault |
| vc_reset | output | 1 | Catch on reset |

## Verification
A corrupted control bit shows on halt_req, step_req or mask_int in the cycle after the faulty write. It also shows in the low nibble of the next status read, so a key check that misfires is caught within one access. Sticky or cause state that is lost or stuck shows only when the debugger reads it. For that reason the bench reads immediately after each event and again after each clear. A transfer state machine that is wrong shows in the cycle after the selector write, as a missing or doubled xfer_req, or as ready not dropping. After the done pulse it shows as a data word holding the wrong value.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam logic [15:0] CTL_KEY = 16'hA05F;

  localparam logic [2:0] A_CTL   = 3'd0;
  localparam logic [2:0] A_CAUSE = 3'd1;
  localparam logic [2:0] A_SEL   = 3'd2;
  localparam logic [2:0] A_DATA  = 3'd3;
  localparam logic [2:0] A_MON   = 3'd4;

  // Status word bit positions (read side of address 0)
  localparam int B_RST_FLAG = 25;
  localparam int B_RET_FLAG = 24;
  localparam int B_LOCKUP   = 19;
  localparam int B_SLEEP    = 18;
  localparam int B_HALTED   = 17;
  localparam int B_READY    = 16;

  localparam int B_SEL_DIR  = 16;

  localparam int B_MON_WATCH = 24;
  localparam int B_MON_HF    = 10;
  localparam int B_MON_RST   = 0;

  typedef struct packed {
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctl_t;

  function automatic logic key_ok(input logic [15:0] key);
    return key == CTL_KEY;
  endfunction

  // Sticky bit update: set dominates clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_halt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_key,
  input  logic [3:0]  wr_ctl,
  input  logic        rd_en,
  input  logic        core_reset,
  input  logic        core_retire,
  output ctl_t        ctl_q,
  output logic        rst_flag,
  output logic        ret_flag,
  output logic        key_reject
);
  logic key_accept;

  assign key_accept = wr_en & key_ok(wr_key);
  assign key_reject = wr_en & ~key_ok(wr_key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      rst_flag <= 1'b0;
      ret_flag <= 1'b0;
    end else begin
      if (key_accept) ctl_q <= ctl_t'(wr_ctl);
      rst_flag <= sticky_next(rst_flag, core_reset, rd_en);
      ret_flag <= sticky_next(ret_flag, core_retire, rd_en);
    end
  end
endmodule

// File: rtl/dbg_cause_reg.sv
module dbg_cause_reg
  import dbg_halt_pkg::*;
#(
  parameter int N_CAUSE = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [N_CAUSE-1:0] wr_ones,
  input  logic [N_CAUSE-1:0] ev,
  output logic [N_CAUSE-1:0] cause_q
);
  for (genvar i = 0; i < N_CAUSE; i++) begin : g_bit
    logic clr;
    assign clr = wr_en & wr_ones[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q[i] <= 1'b0;
      else        cause_q[i] <= sticky_next(cause_q[i], ev[i], clr);
    end
  end
endmodule

// File: rtl/dbg_xfer.sv
module dbg_xfer #(
  parameter int DW    = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic             sel_dir,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             data_wr,
  input  logic [DW-1:0]    data_in,
  input  logic             done,
  input  logic [DW-1:0]    core_rdata,
  output logic             req,
  output logic             dir_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [DW-1:0]    data_q,
  output logic             ready
);
  logic capture;

  assign capture = done & ~dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req   <= 1'b0;
      dir_q <= 1'b0;
      idx_q <= '0;
      ready <= 1'b1;
    end else begin
      req <= sel_wr;
      if (sel_wr) begin
        dir_q <= sel_dir;
        idx_q <= sel_idx;
        ready <= 1'b0;
      end else if (done) begin
        ready <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_wr) data_q <= data_in;
    else if (capture) data_q <= core_rdata;
  end
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbg_halt_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int IDX_W   = 5,
  parameter int N_CAUSE = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic               core_halted,
  input  logic               core_sleep,
  input  logic               core_lockup,
  input  logic               core_reset,
  input  logic               core_retire,
  input  logic               core_xfer_done,
  input  logic [DW-1:0]      core_xfer_rdata,
  input  logic [N_CAUSE-1:0] cause_ev,
  output logic               halt_req,
  output logic               step_req,
  output logic               mask_int,
  output logic               xfer_req,
  output logic               xfer_write,
  output logic [IDX_W-1:0]   xfer_index,
  output logic [DW-1:0]      xfer_wdata,
  output logic               watch_en,
  output logic               vc_hardfault,
  output logic               vc_reset
);
  // Named access strobes
  logic wr_ctl, wr_cause, wr_sel, wr_data, wr_mon, rd_ctl;
  assign wr_ctl   = bus_sel & bus_wr  & (bus_addr == AW'(A_CTL));
  assign wr_cause = bus_sel & bus_wr  & (bus_addr == AW'(A_CAUSE));
  assign wr_sel   = bus_sel & bus_wr  & (bus_addr == AW'(A_SEL));
  assign wr_data  = bus_sel & bus_wr  & (bus_addr == AW'(A_DATA));
  assign wr_mon   = bus_sel & bus_wr  & (bus_addr == AW'(A_MON));
  assign rd_ctl   = bus_sel & ~bus_wr & (bus_addr == AW'(A_CTL));

  ctl_t               ctl_q;
  logic               rst_flag, ret_flag, key_reject;
  logic [N_CAUSE-1:0] cause_q;
  logic               xfer_ready;
  logic               mon_watch, mon_hf, mon_rst;

  dbg_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_ctl),
    .wr_key     (bus_wdata[DW-1:DW-16]),
    .wr_ctl     (bus_wdata[3:0]),
    .rd_en      (rd_ctl),
    .core_reset (core_reset),
    .core_retire(core_retire),
    .ctl_q      (ctl_q),
    .rst_flag   (rst_flag),
    .ret_flag   (ret_flag),
    .key_reject (key_reject)
  );

  dbg_cause_reg #(.N_CAUSE(N_CAUSE)) u_cause (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_cause),
    .wr_ones(bus_wdata[N_CAUSE-1:0]),
    .ev     (cause_ev),
    .cause_q(cause_q)
  );

  dbg_xfer #(.DW(DW), .IDX_W(IDX_W)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wr    (wr_sel),
    .sel_dir   (bus_wdata[B_SEL_DIR]),
    .sel_idx   (bus_wdata[IDX_W-1:0]),
    .data_wr   (wr_data),
    .data_in   (bus_wdata),
    .done      (core_xfer_done),
    .core_rdata(core_xfer_rdata),
    .req       (xfer_req),
    .dir_q     (xfer_write),
    .idx_q     (xfer_index),
    .data_q    (xfer_wdata),
    .ready     (xfer_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_watch <= 1'b0;
      mon_hf    <= 1'b0;
      mon_rst   <= 1'b0;
    end else if (wr_mon) begin
      mon_watch <= bus_wdata[B_MON_WATCH];
      mon_hf    <= bus_wdata[B_MON_HF];
      mon_rst   <= bus_wdata[B_MON_RST];
    end
  end

  assign watch_en     = mon_watch;
  assign vc_hardfault = mon_hf;
  assign vc_reset     = mon_rst;

  // Run-control requests gated by debug enable
  assign halt_req = ctl_q.en & ctl_q.halt;
  assign step_req = ctl_q.en & ctl_q.step;
  assign mask_int = ctl_q.en & ctl_q.mask;

  // Read words
  logic [DW-1:0] ctl_word, cause_word, sel_word, mon_word;
  always_comb begin
    ctl_word             = '0;
    ctl_word[3:0]        = ctl_q;
    ctl_word[B_READY]    = xfer_ready;
    ctl_word[B_HALTED]   = core_halted;
    ctl_word[B_SLEEP]    = core_sleep;
    ctl_word[B_LOCKUP]   = core_lockup;
    ctl_word[B_RET_FLAG] = ret_flag;
    ctl_word[B_RST_FLAG] = rst_flag;

    cause_word                = '0;
    cause_word[N_CAUSE-1:0]   = cause_q;

    sel_word                  = '0;
    sel_word[IDX_W-1:0]       = xfer_index;
    sel_word[B_SEL_DIR]       = xfer_write;

    mon_word                  = '0;
    mon_word[B_MON_WATCH]     = mon_watch;
    mon_word[B_MON_HF]        = mon_hf;
    mon_word[B_MON_RST]       = mon_rst;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        AW'(A_CTL):   bus_rdata = ctl_word;
        AW'(A_CAUSE): bus_rdata = cause_word;
        AW'(A_SEL):   bus_rdata = sel_word;
        AW'(A_DATA):  bus_rdata = xfer_wdata;
        AW'(A_MON):   bus_rdata = mon_word;
        default:      bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_halt_ctl_chk.sv
module dbg_halt_ctl_chk
  import dbg_halt_pkg::*;
#(
  parameter int AW      = 3,
  parameter int N_CAUSE = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [AW-1:0]      bus_addr,
  input logic               core_reset,
  input logic               core_xfer_done,
  input logic [N_CAUSE-1:0] cause_ev,
  input logic               xfer_req,
  input logic               halt_req,
  input logic [3:0]         ctl_bits,
  input logic               key_reject,
  input logic               rst_flag,
  input logic [N_CAUSE-1:0] cause_q,
  input logic               xfer_ready
);
  logic sel_wr;
  assign sel_wr = bus_sel & bus_wr & (bus_addr == AW'(A_SEL));

  p_key_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_reject |=> $stable(ctl_bits));

  p_halt_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> ctl_bits[0]);

  p_reset_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> rst_flag);

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|cause_ev) |=> ((cause_q & $past(cause_ev)) == $past(cause_ev)));

  p_req_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> $past(sel_wr));

  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> !xfer_ready);

  p_ready_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_xfer_done && !sel_wr) |=> xfer_ready);
endmodule

bind dbg_halt_ctl dbg_halt_ctl_chk #(.AW(AW), .N_CAUSE(N_CAUSE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_sel       (bus_sel),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .core_reset    (core_reset),
  .core_xfer_done(core_xfer_done),
  .cause_ev      (cause_ev),
  .xfer_req      (xfer_req),
  .halt_req      (halt_req),
  .ctl_bits      (ctl_q),
  .key_reject    (key_reject),
  .rst_flag      (rst_flag),
  .cause_q       (cause_q),
  .xfer_ready    (xfer_ready)
);

// File: tb/dbg_halt_ctl_bench.sv
module dbg_halt_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_halted = 0, core_sleep = 0, core_lockup = 0, core_reset = 0;
  logic        core_retire = 0, core_xfer_done = 0;
  logic [31:0] core_xfer_rdata = '0;
  logic [4:0]  cause_ev = '0;
  logic        halt_req, step_req, mask_int, xfer_req, xfer_write;
  logic [4:0]  xfer_index;
  logic [31:0] xfer_wdata;
  logic        watch_en, vc_hardfault, vc_reset;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  logic [4:0] pend_ev = '0;

  always #10 clk = ~clk;  // 50 MHz

  dbg_halt_ctl u_dbg_halt_ctl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_halted(core_halted), .core_sleep(core_sleep), .core_lockup(core_lockup),
    .core_reset(core_reset), .core_retire(core_retire),
    .core_xfer_done(core_xfer_done), .core_xfer_rdata(core_xfer_rdata),
    .cause_ev(cause_ev), .halt_req(halt_req), .step_req(step_req),
    .mask_int(mask_int), .xfer_req(xfer_req), .xfer_write(xfer_write),
    .xfer_index(xfer_index), .xfer_wdata(xfer_wdata), .watch_en(watch_en),
    .vc_hardfault(vc_hardfault), .vc_reset(vc_reset)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected status word from the bench's own view of state
  function automatic logic [31:0] exp_status(input logic [3:0] c, input logic rdy,
                                             input logic rf, input logic tf);
    logic [31:0] w;
    w = 32'h0;
    w = w | {28'h0, c};
    w = w | (rdy ? 32'h0001_0000 : 32'h0);
    w = w | (core_halted ? 32'h0002_0000 : 32'h0);
    w = w | (core_sleep  ? 32'h0004_0000 : 32'h0);
    w = w | (core_lockup ? 32'h0008_0000 : 32'h0);
    w = w | (tf ? 32'h0100_0000 : 32'h0);
    w = w | (rf ? 32'h0200_0000 : 32'h0);
    return w;
  endfunction

  function automatic logic [4:0] exp_cause(input logic [4:0] cur, input logic [4:0] ev,
                                           input logic [4:0] ones);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = ev[i] ? 1'b1 : (ones[i] ? 1'b0 : cur[i]);
    return r;
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; cause_ev = pend_ev;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; cause_ev = '0; pend_ev = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [3:0]  mctl;
    logic [4:0]  mcause;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk("R1 outputs", {24'h0, halt_req, step_req, mask_int, xfer_req,
                       xfer_write, watch_en, vc_hardfault, vc_reset}, 32'h0);
    bus_read(3'd0, rd); chk("R1 status", rd, 32'h0001_0000);
    bus_read(3'd1, rd); chk("R1 cause", rd, 32'h0);
    bus_read(3'd2, rd); chk("R1 selector", rd, 32'h0);
    bus_read(3'd4, rd); chk("R1 monitor", rd, 32'h0);

    // R2 directed: keyed write then unkeyed write
    mctl = 4'h0;
    bus_write(3'd0, 32'hA05F_0003); mctl = 4'h3;
    chk("R2 halt after keyed write", {31'h0, halt_req}, 32'h1);
    bus_write(3'd0, 32'hA05E_0000);
    bus_read(3'd0, rd); chk("R2 unkeyed write ignored", rd, exp_status(mctl, 1, 0, 0));
    bus_write(3'd0, 32'h0000_000F);
    chk("R2 zero key ignored", {29'h0, halt_req, step_req, mask_int}, 32'h4);

    // R3: controls without enable
    bus_write(3'd0, 32'hA05F_000E); mctl = 4'hE;
    chk("R3 gated by enable", {29'h0, halt_req, step_req, mask_int}, 32'h0);

    // R2/R3 random
    for (int i = 0; i < 150; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom % 2) d[31:16] = 16'hA05F;
      bus_write(3'd0, d);
      if (d[31:16] == 16'hA05F) mctl = d[3:0];
      chk("R3 request outputs", {29'h0, halt_req, step_req, mask_int},
          {29'h0, mctl[0] & mctl[1], mctl[0] & mctl[2], mctl[0] & mctl[3]});
      bus_read(3'd0, rd);
      chk("R2 control bits", rd, exp_status(mctl, 1, 0, 0));
    end

    // R4 live status
    core_lockup = 1; core_halted = 1; core_sleep = 0;
    bus_read(3'd0, rd); chk("R4 lockup/halted", rd, exp_status(mctl, 1, 0, 0));
    core_lockup = 0; core_halted = 0; core_sleep = 1;
    bus_read(3'd0, rd); chk("R4 sleep", rd, exp_status(mctl, 1, 0, 0));
    core_sleep = 0;

    // R5 sticky reset flag
    @(negedge clk); core_reset = 1;
    @(negedge clk); core_reset = 0;
    bus_read(3'd0, rd); chk("R5 reset flag set", rd, exp_status(mctl, 1, 1, 0));
    bus_read(3'd0, rd); chk("R5 reset flag cleared by read", rd, exp_status(mctl, 1, 0, 0));
    @(negedge clk); core_reset = 1;
    bus_read(3'd0, rd); chk("R5 read while reset held", rd, exp_status(mctl, 1, 1, 0));
    core_reset = 0;
    bus_read(3'd0, rd); chk("R5 flag survives read during reset", rd, exp_status(mctl, 1, 1, 0));
    bus_read(3'd0, rd); chk("R5 flag then cleared", rd, exp_status(mctl, 1, 0, 0));

    // R6 retire flag
    @(negedge clk); core_retire = 1;
    @(negedge clk); core_retire = 0;
    bus_read(3'd0, rd); chk("R6 retire flag set", rd, exp_status(mctl, 1, 0, 1));
    bus_read(3'd0, rd); chk("R6 retire flag cleared", rd, exp_status(mctl, 1, 0, 0));

    // R7 cause register: directed, then random
    mcause = '0;
    pend_ev = 5'b10010;
    bus_write(3'd1, 32'h0000_0000); mcause = 5'b10010;
    bus_read(3'd1, rd); chk("R7 events set", rd, {27'h0, mcause});
    bus_write(3'd1, 32'h0000_0002); mcause = 5'b10000;
    bus_read(3'd1, rd); chk("R7 write-one clears", rd, {27'h0, mcause});
    pend_ev = 5'b10000;
    bus_write(3'd1, 32'h0000_0010);
    bus_read(3'd1, rd); chk("R7 event beats clear", rd, {27'h0, mcause});
    for (int i = 0; i < 100; i++) begin
      logic [4:0] ev, ones;
      logic [2:0] a;
      ev = 5'($urandom); ones = 5'($urandom);
      a = ($urandom % 4 == 0) ? 3'd5 : 3'd1;
      pend_ev = ev;
      bus_write(a, {27'h7FFFFFF, ones});
      mcause = exp_cause(mcause, ev, (a == 3'd1) ? ones : 5'h0);
      bus_read(3'd1, rd); chk("R7 random cause", rd, {27'h0, mcause});
    end

    // R8 selector write starts a write-direction transfer
    bus_write(3'd3, 32'h1357_9BDF);
    chk("R10 data drives xfer_wdata", xfer_wdata, 32'h1357_9BDF);
    bus_write(3'd2, 32'hFFFF_FFF7);
    chk("R8 request pulse", {30'h0, xfer_req, xfer_write}, 32'h3);
    chk("R8 index", {27'h0, xfer_index}, 32'h17);
    @(negedge clk);
    chk("R8 request lasts one cycle", {31'h0, xfer_req}, 32'h0);
    bus_read(3'd0, rd); chk("R8 ready cleared", rd, exp_status(mctl, 0, 0, 0));
    bus_read(3'd2, rd); chk("R8 selector readback", rd, 32'h0001_0017);
    @(negedge clk); core_xfer_done = 1; core_xfer_rdata = 32'hDEAD_0001;
    @(negedge clk); core_xfer_done = 0;
    bus_read(3'd3, rd); chk("R9 write dir keeps data", rd, 32'h1357_9BDF);
    bus_read(3'd0, rd); chk("R9 ready set", rd, exp_status(mctl, 1, 0, 0));

    // R9 read-direction transfer
    bus_write(3'd2, 32'h0000_0003);
    chk("R8 read direction", {27'h0, xfer_write, xfer_req, xfer_index[2:0]}, 32'h0B);
    @(negedge clk); core_xfer_done = 1; core_xfer_rdata = 32'hCAFE_1234;
    @(negedge clk); core_xfer_done = 0;
    bus_read(3'd3, rd); chk("R9 data captured", rd, 32'hCAFE_1234);
    chk("R9 captured on xfer_wdata", xfer_wdata, 32'hCAFE_1234);

    // R11 monitor
    bus_write(3'd4, 32'hFFFF_FFFF);
    bus_read(3'd4, rd); chk("R11 monitor readback", rd, 32'h0100_0401);
    chk("R11 outputs", {29'h0, watch_en, vc_hardfault, vc_reset}, 32'h7);
    bus_write(3'd4, 32'h0000_0400);
    chk("R11 outputs partial", {29'h0, watch_en, vc_hardfault, vc_reset}, 32'h2);

    // R12 unmapped addresses
    for (int a = 5; a < 8; a++) begin
      bus_write(3'(a), 32'hFFFF_FFFF);
      bus_read(3'(a), rd); chk("R12 unmapped reads zero", rd, 32'h0);
    end
    bus_read(3'd1, rd); chk("R12 unmapped write left cause", rd, {27'h0, mcause});

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule